// File: doc/BRIEF.md
# Bunch-Synchronous Start and Trigger Sequencer

This block runs in the bunch-clock domain and produces the timing strobes that frame each bunch train for the front-end electronics. Every train begins with a start strobe. A programmable number of bunch-clock periods later come a train-start strobe and a calibration trigger, and after a programmable train length comes a train-end strobe. The start can come from an external trigger input. In standalone mode it is instead produced by an internal period counter, so a crate can run with no machine timing at all.

Run control is tied to the data-acquisition cycle. Software writes a run request through a small register interface. The request only takes effect on the next DAQ-ready event, so enabling, pausing and resuming all land on a cycle boundary. The slave status line is a wired-OR error input. When error inhibit is enabled, an asserted error latches a sticky flag that blocks further starts until software clears it. A start that arrives while a train sequence is still counting is dropped and recorded in a sticky overrun flag. A train counter advances on every train end.

Top module: `bunch_start_seq`

## Requirements
- R1: After a synchronous reset, all four strobe outputs are low, and every register reads zero: control (addr 0), offset (1), trigger delay (2), length (3), period (4), flags (5) and train count (6).
- R2: When a start is accepted, the start strobe goes high for exactly one cycle, in the cycle that follows the clock edge that sampled the start.
- R3: The train-start strobe is one cycle wide and comes the offset-register value (addr 1) cycles after the start strobe. A value of 0 means the same cycle.
- R4: The calibration trigger is one cycle wide and comes the trigger-delay value (addr 2) cycles after the start strobe. It is independent of the offset and the length.
- R5: The train-end strobe is one cycle wide and comes offset plus length (addr 3) cycles after the start strobe.
- R6: Control bit 0 (run request) is copied to the internal active state only on a clock edge where daq_ready is high. Starts are accepted only while active. A train already in progress completes. Flags bit 2 reads the active state.
- R7: A start that arrives while a sequence is in progress (from the start strobe through the later of train end and trigger) is ignored, and it sets the sticky overrun flag (flags bit 0). A start in the cycle after that window is accepted. Writing 1 to flags bit 0 clears the flag.
- R8: With control bit 2 set, slave_err high sets the sticky inhibit flag (flags bit 1), which blocks every start until software writes 1 to flags bit 1. With control bit 2 clear, slave_err has no effect.
- R9: With control bit 1 set (standalone) and the block active, starts are generated internally every period-register (addr 4) cycles, and ext_start is ignored.
- R10: The train counter (addr 6) increments once per train-end strobe. Writing 1 to bit 0 of addr 6 clears it.
- R11: Asserting reset mid-train stops the sequence at once, drops the active state, and leaves no strobe pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register address |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Register read data (combinational) |
| ext_start | input | 1 | External start trigger, one cycle pulse |
| daq_ready | input | 1 | DAQ-ready event, one cycle pulse |
| slave_err | input | 1 | Wired-OR slave error status |
| start_o | output | 1 | Start strobe |
| train_start_o | output | 1 | Train-start strobe |
| train_end_o | output | 1 | Train-end strobe |
| cal_trig_o | output | 1 | Calibration trigger strobe |

## Verification
The bench builds the block with a 6-bit delay counter and an 8-bit train counter. With those sizes it can sweep every combination of offset 0 to 3, length 0 to 3 and trigger delay 0 to 5, and confirm the position and single occurrence of each strobe. The small widths also keep the overrun window short. That lets the bench place a second start on the last busy cycle and on the first idle cycle, and run several standalone periods inside a short window.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL   = 3'd0,
    A_OFFSET = 3'd1,
    A_TRIG   = 3'd2,
    A_LEN    = 3'd3,
    A_PERIOD = 3'd4,
    A_FLAGS  = 3'd5,
    A_TRAINS = 3'd6
  } reg_addr_e;

  // bit 0 run request, bit 1 standalone, bit 2 error inhibit enable
  typedef struct packed {
    logic err_inh_en;
    logic standalone;
    logic run_req;
  } ctrl_t;
endpackage

// File: rtl/bsq_csr.sv
module bsq_csr
  import bsq_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int TRAIN_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [REG_AW-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output ctrl_t                ctrl,
  output logic [CNT_W-1:0]     offset,
  output logic [CNT_W-1:0]     trig_dly,
  output logic [CNT_W-1:0]     train_len,
  output logic [CNT_W-1:0]     period,
  input  logic                 ovr_set,
  input  logic                 inh_set,
  input  logic                 train_tick,
  input  logic                 active_i,
  output logic                 ovr_q,
  output logic                 inh_q
);
  logic [TRAIN_W-1:0] train_cnt;
  logic ovr_clr, inh_clr, cnt_clr;
  logic wdata_unused;

  assign wdata_unused = &{1'b0, wdata};
  assign ovr_clr = we && (addr == A_FLAGS)  && wdata[0];
  assign inh_clr = we && (addr == A_FLAGS)  && wdata[1];
  assign cnt_clr = we && (addr == A_TRAINS) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      offset    <= '0;
      trig_dly  <= '0;
      train_len <= '0;
      period    <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL:   ctrl      <= ctrl_t'(wdata[2:0]);
        A_OFFSET: offset    <= wdata[CNT_W-1:0];
        A_TRIG:   trig_dly  <= wdata[CNT_W-1:0];
        A_LEN:    train_len <= wdata[CNT_W-1:0];
        A_PERIOD: period    <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // sticky flags: a new event wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      inh_q <= 1'b0;
    end else begin
      if (ovr_set)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
      if (inh_set)      inh_q <= 1'b1;
      else if (inh_clr) inh_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr)  train_cnt <= '0;
    else if (train_tick) train_cnt <= train_cnt + TRAIN_W'(1);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata = DATA_W'(ctrl);
      A_OFFSET: rdata = DATA_W'(offset);
      A_TRIG:   rdata = DATA_W'(trig_dly);
      A_LEN:    rdata = DATA_W'(train_len);
      A_PERIOD: rdata = DATA_W'(period);
      A_FLAGS:  rdata = DATA_W'({active_i, inh_q, ovr_q});
      A_TRAINS: rdata = DATA_W'(train_cnt);
      default:  rdata = '0;
    endcase
  end

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_q && !ovr_clr |=> ovr_q); // R7
  AST_INHIBIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    inh_q && !inh_clr |=> inh_q); // R8
  AST_TRAIN_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    train_tick && !cnt_clr |=> train_cnt == $past(train_cnt) + TRAIN_W'(1)); // R10
endmodule

// File: rtl/bsq_src.sv
module bsq_src
  import bsq_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] period,
  input  logic             ext_start,
  input  logic             daq_ready,
  input  logic             slave_err,
  input  logic             inh_q,
  input  logic             busy,
  output logic             active,
  output logic             issue,
  output logic             ovr_set,
  output logic             inh_set
);
  logic [CNT_W-1:0] phase;
  logic cand, allowed;

  // next phase of the standalone period counter; periods of 0 or 1 wrap every cycle
  function automatic logic [CNT_W-1:0] next_phase(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] per);
    if (per <= CNT_W'(1) || cur >= per - CNT_W'(1)) return '0;
    return cur + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)            active <= 1'b0;
    else if (daq_ready) active <= ctrl.run_req;
  end

  always_ff @(posedge clk) begin
    if (rst || !active || !ctrl.standalone) phase <= '0;
    else                                    phase <= next_phase(phase, period);
  end

  assign cand    = ctrl.standalone ? (active && phase == '0) : ext_start;
  assign allowed = cand && active && !inh_q;
  assign issue   = allowed && !busy;
  assign ovr_set = allowed && busy;
  assign inh_set = slave_err && ctrl.err_inh_en;

  AST_NO_ISSUE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !issue); // R7
endmodule

// File: rtl/bsq_timer.sv
module bsq_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [CNT_W-1:0] offset,
  input  logic [CNT_W-1:0] trig_dly,
  input  logic [CNT_W-1:0] train_len,
  output logic             busy,
  output logic             start_o,
  output logic             train_start_o,
  output logic             train_end_o,
  output logic             cal_trig_o
);
  localparam int W = CNT_W + 1;

  logic [W-1:0] cnt;
  logic [W-1:0] end_at, last_at;

  function automatic logic [W-1:0] end_tick(input logic [CNT_W-1:0] off,
                                            input logic [CNT_W-1:0] len);
    return {1'b0, off} + {1'b0, len};
  endfunction

  function automatic logic [W-1:0] last_tick(input logic [CNT_W-1:0] off,
                                             input logic [CNT_W-1:0] len,
                                             input logic [CNT_W-1:0] dly);
    logic [W-1:0] e;
    e = end_tick(off, len);
    return (e >= {1'b0, dly}) ? e : {1'b0, dly};
  endfunction

  assign end_at  = end_tick(offset, train_len);
  assign last_at = last_tick(offset, train_len, trig_dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (issue) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt >= last_at) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end

  assign start_o       = busy && (cnt == '0);
  assign train_start_o = busy && (cnt == {1'b0, offset});
  assign cal_trig_o    = busy && (cnt == {1'b0, trig_dly});
  assign train_end_o   = busy && (cnt == end_at);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R2
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    train_end_o |=> !train_end_o); // R5
endmodule

// File: rtl/bunch_start_seq.sv
module bunch_start_seq
  import bsq_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int TRAIN_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              ext_start,
  input  logic              daq_ready,
  input  logic              slave_err,
  output logic              start_o,
  output logic              train_start_o,
  output logic              train_end_o,
  output logic              cal_trig_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] offset, trig_dly, train_len, period;
  logic             ovr_set, inh_set, ovr_q, inh_q;
  logic             active, issue, busy;

  bsq_csr #(.CNT_W(CNT_W), .TRAIN_W(TRAIN_W), .DATA_W(DATA_W)) u_csr (
    .clk(clk), .rst(rst), .we(csr_we), .addr(csr_addr), .wdata(csr_wdata),
    .rdata(csr_rdata), .ctrl(ctrl), .offset(offset), .trig_dly(trig_dly),
    .train_len(train_len), .period(period), .ovr_set(ovr_set),
    .inh_set(inh_set), .train_tick(train_end_o), .active_i(active),
    .ovr_q(ovr_q), .inh_q(inh_q)
  );

  bsq_src #(.CNT_W(CNT_W)) u_src (
    .clk(clk), .rst(rst), .ctrl(ctrl), .period(period), .ext_start(ext_start),
    .daq_ready(daq_ready), .slave_err(slave_err), .inh_q(inh_q), .busy(busy),
    .active(active), .issue(issue), .ovr_set(ovr_set), .inh_set(inh_set)
  );

  bsq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .issue(issue), .offset(offset), .trig_dly(trig_dly),
    .train_len(train_len), .busy(busy), .start_o(start_o),
    .train_start_o(train_start_o), .train_end_o(train_end_o),
    .cal_trig_o(cal_trig_o)
  );

  AST_ISSUE_TO_START: assert property (@(posedge clk) disable iff (rst)
    issue |=> start_o); // R2
  AST_START_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(active)); // R6
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    inh_q |=> !start_o); // R8
endmodule

// File: tb/sim_bunch_start_seq.sv
`timescale 1ns/1ps
module sim_bunch_start_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        ext_start = 1'b0, daq_ready = 1'b0, slave_err = 1'b0;
  logic        start_o, train_start_o, train_end_o, cal_trig_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bunch_start_seq #(.CNT_W(6), .TRAIN_W(8), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ext_start(ext_start),
    .daq_ready(daq_ready), .slave_err(slave_err), .start_o(start_o),
    .train_start_o(train_start_o), .train_end_o(train_end_o),
    .cal_trig_o(cal_trig_o)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    report();
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    csr_we = 1'b1; csr_addr = 3'(a); csr_wdata = 32'(d);
    tick();
    csr_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    csr_addr = 3'(a);
    #1;
    d = int'(csr_rdata);
  endtask

  task automatic daq();
    daq_ready = 1'b1; tick(); daq_ready = 1'b0;
  endtask

  // fires a start, optionally raises ext_start again in cycle hit_at,
  // returns number of start strobes and position of the second one
  task automatic probe(int hit_at, int span, output int n_s, output int p2);
    n_s = 0; p2 = -1;
    ext_start = 1'b1; tick(); ext_start = 1'b0;
    for (int n = 0; n < span; n++) begin
      if (start_o) begin
        n_s++;
        if (n_s == 2) p2 = n;
      end
      ext_start = (n == hit_at);
      tick();
    end
    ext_start = 1'b0;
  endtask

  task automatic sweep_one(int off, int len, int dly);
    int last, c_s, c_ts, c_tr, c_te, p_s, p_ts, p_tr, p_te;
    wr(1, off); wr(2, dly); wr(3, len);
    last = (off + len > dly) ? off + len : dly;
    c_s = 0; c_ts = 0; c_tr = 0; c_te = 0;
    p_s = -1; p_ts = -1; p_tr = -1; p_te = -1;
    ext_start = 1'b1; tick(); ext_start = 1'b0;
    for (int n = 0; n <= last + 2; n++) begin
      if (start_o)       begin c_s++;  p_s  = n; end
      if (train_start_o) begin c_ts++; p_ts = n; end
      if (cal_trig_o)    begin c_tr++; p_tr = n; end
      if (train_end_o)   begin c_te++; p_te = n; end
      tick();
    end
    check("R2 start strobe position", (c_s == 1) ? p_s : -1, 0);
    check("R3 train start position", (c_ts == 1) ? p_ts : -1, off);
    check("R4 calibration trigger position", (c_tr == 1) ? p_tr : -1, dly);
    check("R5 train end position", (c_te == 1) ? p_te : -1, off + len);
  endtask

  initial begin : main
    int v, ns, p2, first, prev, gaps_ok, cnt_s;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check($sformatf("R1 register %0d after reset", a), v, 0);
    end
    check("R1 strobes low after reset",
          int'({start_o, train_start_o, train_end_o, cal_trig_o}), 0);

    // enable: run request then DAQ-ready
    wr(0, 1);
    daq();

    // R2..R5 sweep
    for (int off = 0; off < 4; off++)
      for (int len = 0; len < 4; len++)
        for (int dly = 0; dly < 6; dly++)
          sweep_one(off, len, dly);

    // R10 train counter
    rd(6, v);
    check("R10 train count after sweep", v, 96);
    wr(6, 1);
    rd(6, v);
    check("R10 train count cleared", v, 0);

    // R6 run request gated by DAQ-ready
    wr(1, 2); wr(2, 0); wr(3, 2);  // last = 4
    wr(0, 0);
    probe(-1, 10, ns, p2);
    check("R6 starts still accepted before DAQ-ready (pause pending)", ns, 1);
    rd(5, v);
    check("R6 active still set before DAQ-ready", (v >> 2) & 1, 1);
    daq();
    rd(5, v);
    check("R6 active cleared at DAQ-ready", (v >> 2) & 1, 0);
    probe(-1, 10, ns, p2);
    check("R6 start ignored while paused", ns, 0);
    wr(0, 1);
    probe(-1, 10, ns, p2);
    check("R6 resume request not applied before DAQ-ready", ns, 0);
    daq();
    probe(-1, 10, ns, p2);
    check("R6 start accepted after resume at DAQ-ready", ns, 1);
    // pause during a train: the train completes
    ext_start = 1'b1; tick(); ext_start = 1'b0;
    wr(0, 0);
    daq_ready = 1'b1; tick(); daq_ready = 1'b0;
    cnt_s = 0;
    for (int n = 2; n < 8; n++) begin
      if (train_end_o) cnt_s = n;
      tick();
    end
    check("R6 train in progress completes after pause", cnt_s, 4);
    wr(0, 1); daq();

    // R7 overrun
    wr(5, 1);
    probe(2, 16, ns, p2);
    check("R7 start during count ignored", ns, 1);
    rd(5, v);
    check("R7 overrun flag set", v & 1, 1);
    wr(5, 1);
    rd(5, v);
    check("R7 overrun flag cleared by write of one", v & 1, 0);
    probe(4, 16, ns, p2);
    check("R7 start on last busy cycle ignored", ns, 1);
    rd(5, v);
    check("R7 overrun on last busy cycle", v & 1, 1);
    wr(5, 1);
    probe(5, 16, ns, p2);
    check("R7 start on first idle cycle accepted", p2, 6);
    rd(5, v);
    check("R7 no overrun on first idle cycle", v & 1, 0);

    // R8 error inhibit
    wr(0, 5);
    slave_err = 1'b1; tick(); slave_err = 1'b0;
    rd(5, v);
    check("R8 inhibit flag set by slave error", (v >> 1) & 1, 1);
    probe(-1, 10, ns, p2);
    check("R8 start blocked while inhibited", ns, 0);
    wr(5, 2);
    rd(5, v);
    check("R8 inhibit flag cleared by write of one", (v >> 1) & 1, 0);
    probe(-1, 10, ns, p2);
    check("R8 start accepted after clear", ns, 1);
    wr(0, 1);
    slave_err = 1'b1; tick(); slave_err = 1'b0;
    rd(5, v);
    check("R8 slave error ignored with inhibit disabled", (v >> 1) & 1, 0);
    probe(-1, 10, ns, p2);
    check("R8 start accepted with inhibit disabled", ns, 1);

    // R9 standalone generation every 5 cycles, ext_start ignored
    wr(1, 0); wr(2, 0); wr(3, 1); wr(4, 5);
    wr(0, 3);
    first = -1; prev = -1; gaps_ok = 1; cnt_s = 0;
    for (int n = 0; n < 30; n++) begin
      if (start_o) begin
        cnt_s++;
        if (prev >= 0 && n - prev != 5) gaps_ok = 0;
        if (first < 0) first = n;
        prev = n;
      end
      ext_start = (n % 7 == 3);
      tick();
    end
    ext_start = 1'b0;
    check("R9 standalone start count in 30 cycles", cnt_s, 6);
    check("R9 standalone start spacing equals period", gaps_ok, 1);
    wr(0, 1);
    repeat (4) tick();

    // R11 reset mid-train
    wr(1, 3); wr(3, 3);
    ext_start = 1'b1; tick(); ext_start = 1'b0;
    tick();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    cnt_s = 0;
    for (int n = 0; n < 10; n++) begin
      if (start_o || train_start_o || train_end_o || cal_trig_o) cnt_s++;
      tick();
    end
    check("R11 no strobe after mid-train reset", cnt_s, 0);
    rd(5, v);
    check("R11 active dropped by reset", v, 0);
    rd(0, v);
    check("R11 control cleared by reset", v, 0);
    probe(-1, 10, ns, p2);
    check("R11 start ignored after reset until enabled", ns, 0);

    report();
  end
endmodule